// File: doc/BRIEF.md
# Serial Audio Slot Transmit Formatter

This block turns one parallel sample per frame into a serial bit stream on a single data pin. The block is clocked by the bit clock. Each frame-sync pulse latches a word from a holding buffer. The word then passes through a per-bit mask. Each bit whose mask bit is clear is replaced by a pad value: constant zero, constant one, or a copy of one chosen bit of the written word. The result can be bit-reversed. The bits are then shifted out over a slot whose length comes from an input. The first serial bit may appear in the sync cycle itself, or one or two bit clocks after it.

A single format register selects the lead delay, the bit order, the pad mode and the pad-copy index. When the buffer has no fresh word at a frame sync, the previous word is sent again and a one-cycle underrun pulse is raised.

The shift sequencer has three states:
- `ST_IDLE`: the pin is held low.
- `ST_LEAD`: one quiet bit clock before the data.
- `ST_SHIFT`: one bit per clock.

Transitions:
- A sync with lead 0 goes to `ST_SHIFT` at index 1, because bit 0 is driven during the sync cycle itself.
- A sync with lead 1 goes to `ST_SHIFT` at index 0.
- A sync with lead 2 goes to `ST_LEAD`.
- `ST_LEAD` always moves to `ST_SHIFT`.
- `ST_SHIFT` returns to `ST_IDLE` after its last slot bit.
- A sync in any state restarts the sequence.

Top module: `serial_tx_formatter`

## Requirements
- R1: The format register holds the lead delay in bits 17:16, the order select in bit 15, the pad mode in bits 14:13 and the pad-copy index in bits 12:8. Every other bit reads as zero and ignores writes. A write is visible on `cfg_rdata` from the next cycle.
- R2: With lead code 0, stream bit 0 is on `sdo` during the sync cycle. Code 1 moves it one bit clock later and code 2 moves it two later. Code 3 behaves as code 0.
- R3: Stream bit i is bit i of the padded word when the order select is 0. It is bit 31−i of the padded word when the order select is 1.
- R4: A padded-word bit whose `slot_mask` bit is 1 equals the written data bit.
- R5: Pad mode 0 fills bits with a clear mask bit with 0, and pad mode 1 fills them with 1. Reserved pad mode 3 behaves as mode 0.
- R6: Pad mode 2 fills bits with a clear mask bit with the bit of the written word, before mask and reversal, at the pad-copy index. The index has no effect in any other pad mode.
- R7: Each frame sends `slot_len` bits, with values below 8 treated as 8 and values above 32 treated as 32.
- R8: `sdo` is low whenever no slot bit is being sent.
- R9: A sync with `buf_valid` high latches `buf_data` and raises `buf_take` in that same cycle. A sync with `buf_valid` low resends the last latched word and raises `underrun` for exactly the next cycle.
- R10: Reset clears every register field to zero and drives `sdo` and `underrun` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Format register write strobe |
| cfg_wdata | input | 32 | Format register write value |
| cfg_rdata | output | 32 | Format register read value |
| slot_mask | input | 32 | Per-bit keep mask (1 = data, 0 = pad) |
| slot_len | input | 6 | Bits per slot, clamped to 8..32 |
| fsync | input | 1 | Frame sync, one bit clock wide |
| buf_data | input | 32 | Holding buffer word |
| buf_valid | input | 1 | Holding buffer has a fresh word |
| buf_take | output | 1 | Word consumed this cycle |
| sdo | output | 1 | Serial data out |
| underrun | output | 1 | One-cycle pulse after a sync with an empty buffer |

## Verification
The results of this block fall due at different times:
- `buf_take` responds in the sync cycle itself.
- `underrun` and the register readback change one clock later.
- Stream bit i is on `sdo` in cycle lead+i counted from the sync cycle.

The bench drives each input on a falling edge and samples 1 ns later. Sample k therefore sees the cycle k clocks after the sync. The bench builds the expected pin trace from lead, slot length and stream word, with zeros elsewhere, and compares it with the sampled trace as a whole. The `underrun` pulse is checked at samples 1 and 2.

// File: rtl/stf_pkg.sv
`timescale 1ns/1ps
package stf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        PAD_ZERO = 2'd0,
        PAD_ONE  = 2'd1,
        PAD_COPY = 2'd2,
        PAD_RSVD = 2'd3
    } pad_mode_e;

    // packed so that the struct lines up with register bits 17:8
    typedef struct packed {
        logic [1:0] lead;
        logic       msb_first;
        logic [1:0] pad_mode;
        logic [4:0] pad_sel;
    } fmt_cfg_t;

    localparam int unsigned CFG_LSB  = 8;
    localparam int unsigned CFG_BITS = $bits(fmt_cfg_t);
    localparam int unsigned SEL_W    = 5;
endpackage

// File: rtl/stf_cfg_reg.sv
`timescale 1ns/1ps
module stf_cfg_reg
    import stf_pkg::*;
#(
    parameter int unsigned REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output fmt_cfg_t         cfg,
    output logic [REG_W-1:0] rd_data
);
    localparam int unsigned FIELD_MSB = CFG_LSB + CFG_BITS - 1;

    fmt_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= fmt_cfg_t'(wr_data[FIELD_MSB:CFG_LSB]);
        end
    end

    always_comb begin
        rd_data                    = '0;
        rd_data[FIELD_MSB:CFG_LSB] = cfg_q;
    end

    assign cfg = cfg_q;

    wire unused_rsvd = ^{wr_data[REG_W-1:FIELD_MSB+1], wr_data[CFG_LSB-1:0]};

    a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[FIELD_MSB:CFG_LSB] == $past(wr_data[FIELD_MSB:CFG_LSB]));
endmodule

// File: rtl/stf_word_build.sv
`timescale 1ns/1ps
module stf_word_build
    import stf_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned SW = 5
) (
    input  logic [DW-1:0] raw,
    input  logic [DW-1:0] keep,
    input  logic [1:0]    pad_mode,
    input  logic [SW-1:0] pad_sel,
    input  logic          msb_first,
    output logic [DW-1:0] fmt
);
    logic          pad_bit;
    logic [DW-1:0] padded;
    logic [DW-1:0] reversed;

    always_comb begin
        unique case (pad_mode_e'(pad_mode))
            PAD_ONE:  pad_bit = 1'b1;
            PAD_COPY: pad_bit = raw[pad_sel];
            default:  pad_bit = 1'b0;
        endcase
    end

    assign padded = (raw & keep) | (~keep & {DW{pad_bit}});

    for (genvar i = 0; i < DW; i++) begin : g_rev
        assign reversed[i] = padded[DW-1-i];
    end

    assign fmt = msb_first ? reversed : padded;
endmodule

// File: rtl/stf_shifter.sv
`timescale 1ns/1ps
module stf_shifter
    import stf_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fsync,
    input  logic [DW-1:0] word_in,
    input  logic [CW-1:0] len_in,
    input  logic [1:0]    lead_in,
    output logic          sdo
);
    localparam int unsigned IW = $clog2(DW);

    tx_state_e     state_q, state_d;
    logic [CW-1:0] idx_q, idx_d;
    logic [CW-1:0] len_q;
    logic [DW-1:0] word_q;

    // next-state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (fsync) begin
            unique case (lead_in)
                2'd0: begin state_d = ST_SHIFT; idx_d = CW'(1); end
                2'd2: begin state_d = ST_LEAD;  idx_d = '0;     end
                default: begin state_d = ST_SHIFT; idx_d = '0;  end
            endcase
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_LEAD: state_d = ST_SHIFT;
                ST_SHIFT: begin
                    if (idx_q == len_q - CW'(1)) begin
                        state_d = ST_IDLE;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + CW'(1);
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            len_q   <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (fsync) begin
                len_q  <= len_in;
                word_q <= word_in;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:  sdo = fsync && (lead_in == 2'd0) ? word_in[0] : 1'b0;
            ST_LEAD:  sdo = 1'b0;
            ST_SHIFT: sdo = word_q[idx_q[IW-1:0]];
            default:  sdo = 1'b0;
        endcase
    end

    a_r2_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && lead_in == 2'd0) |=> (state_q == ST_SHIFT && idx_q == CW'(1)));
    a_r2_lead_two: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && lead_in == 2'd2) |=> state_q == ST_LEAD);
    a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> idx_q < len_q);
    a_r8_lead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD) |-> !sdo);
endmodule

// File: rtl/serial_tx_formatter.sv
`timescale 1ns/1ps
module serial_tx_formatter
    import stf_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned LEN_W    = 6,
    parameter int unsigned MIN_SLOT = 8,
    parameter int unsigned REG_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic [DATA_W-1:0] slot_mask,
    input  logic [LEN_W-1:0]  slot_len,
    input  logic              fsync,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              buf_valid,
    output logic              buf_take,
    output logic              sdo,
    output logic              underrun
);
    fmt_cfg_t          cfg;
    logic [DATA_W-1:0] held_word;
    logic [DATA_W-1:0] src_word;
    logic [DATA_W-1:0] fmt_word;
    logic [LEN_W-1:0]  eff_len;
    logic [1:0]        eff_lead;

    stf_cfg_reg #(.REG_W(REG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg     (cfg),
        .rd_data (cfg_rdata)
    );

    assign buf_take = fsync & buf_valid;
    assign src_word = buf_valid ? buf_data : held_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_word <= '0;
            underrun  <= 1'b0;
        end else begin
            underrun <= fsync & ~buf_valid;
            if (buf_take) held_word <= buf_data;
        end
    end

    always_comb begin
        if (slot_len < LEN_W'(MIN_SLOT))     eff_len = LEN_W'(MIN_SLOT);
        else if (slot_len > LEN_W'(DATA_W))  eff_len = LEN_W'(DATA_W);
        else                                 eff_len = slot_len;
    end

    assign eff_lead = (cfg.lead == 2'd3) ? 2'd0 : cfg.lead;

    stf_word_build #(.DW(DATA_W), .SW(SEL_W)) u_build (
        .raw       (src_word),
        .keep      (slot_mask),
        .pad_mode  (cfg.pad_mode),
        .pad_sel   (cfg.pad_sel),
        .msb_first (cfg.msb_first),
        .fmt       (fmt_word)
    );

    stf_shifter #(.DW(DATA_W), .CW(LEN_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .fsync   (fsync),
        .word_in (fmt_word),
        .len_in  (eff_len),
        .lead_in (eff_lead),
        .sdo     (sdo)
    );

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        buf_take |=> held_word == $past(buf_data));
    a_r9_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> $past(fsync && !buf_valid));
endmodule

// File: tb/serial_tx_formatter_tb.sv
`timescale 1ns/1ps
module serial_tx_formatter_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [31:0] slot_mask;
    logic [5:0]  slot_len;
    logic        fsync;
    logic [31:0] buf_data;
    logic        buf_valid;
    logic        buf_take;
    logic        sdo;
    logic        underrun;

    always #2.5 clk = ~clk;

    serial_tx_formatter u_dut (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata), .slot_mask (slot_mask), .slot_len (slot_len),
        .fsync (fsync), .buf_data (buf_data), .buf_valid (buf_valid),
        .buf_take (buf_take), .sdo (sdo), .underrun (underrun)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct packed {
        logic [31:0] cfg;
        logic [31:0] mask;
        logic [31:0] data;
        logic [5:0]  slot;
        logic [5:0]  eff;
        logic [1:0]  dly;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h00000000, 32'hFFFFFFFF, 32'hA5A55A5A, 6'd32, 6'd32, 2'd0, 32'hA5A55A5A}, // R2 R4
        '{32'h00010000, 32'h0000FFFF, 32'h12345678, 6'd32, 6'd32, 2'd1, 32'h00005678}, // R2 R5
        '{32'h00022000, 32'h0000FFFF, 32'h12345678, 6'd32, 6'd32, 2'd2, 32'hFFFF5678}, // R2 R5
        '{32'h00004400, 32'h000000FF, 32'h00000010, 6'd32, 6'd32, 2'd0, 32'hFFFFFF10}, // R6
        '{32'h00015F00, 32'h0000FFFF, 32'h80000000, 6'd32, 6'd32, 2'd1, 32'hFFFF0000}, // R6
        '{32'h00008000, 32'hFFFFFFFF, 32'h00000001, 6'd32, 6'd32, 2'd0, 32'h80000000}, // R3
        '{32'h00018000, 32'hFFFFFFFF, 32'h80000003, 6'd8,  6'd8,  2'd1, 32'h00000001}, // R3 R7
        '{32'h00020000, 32'hFFFFFFFF, 32'hFFFFFFFF, 6'd16, 6'd16, 2'd2, 32'h0000FFFF}, // R7 R8
        '{32'h00036000, 32'h0000000F, 32'hFFFFFFFF, 6'd32, 6'd32, 2'd0, 32'h0000000F}, // R2 R5
        '{32'h00002500, 32'h00000000, 32'h00000000, 6'd32, 6'd32, 2'd0, 32'hFFFFFFFF}, // R5
        '{32'h0002C000, 32'hFFFF0000, 32'hABCD0001, 6'd32, 6'd32, 2'd2, 32'hFFFFB3D5}, // R3 R6
        '{32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 6'd4,  6'd8,  2'd0, 32'h000000FF}, // R7
        '{32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 6'd63, 6'd32, 2'd0, 32'hFFFFFFFF}, // R7
        '{32'h00000700, 32'h00000000, 32'hFFFFFFFF, 6'd32, 6'd32, 2'd0, 32'h00000000}  // R6
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // R1: readback one cycle after the write, only bits 17:8 kept
    task automatic write_cfg(input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check(cfg_rdata == (val & 32'h0003FF00), "R1 readback", 64'(cfg_rdata),
              64'(val & 32'h0003FF00));
    endtask

    task automatic run_slot(input logic [31:0] data, input bit valid, input int eff,
                            input int dly, input logic [31:0] exp, input string req);
        logic [39:0] cap  = '0;
        logic [39:0] want = '0;
        @(negedge clk);
        fsync = 1'b1; buf_valid = valid; buf_data = data;
        #1;
        cap[0] = sdo;
        check(buf_take == valid, "R9 take", 64'(buf_take), 64'(valid));
        for (int k = 1; k < eff + dly + 3; k++) begin
            @(negedge clk);
            fsync = 1'b0; buf_valid = 1'b0;
            #1;
            cap[k] = sdo;
            if (k == 1) check(underrun == !valid, "R9 underrun pulse", 64'(underrun), 64'(!valid));
            if (k == 2) check(underrun == 1'b0, "R9 underrun width", 64'(underrun), 64'd0);
        end
        for (int k = 0; k < 40; k++)
            if (k >= dly && k - dly < eff) want[k] = exp[k - dly];
        check(cap == want, req, 64'(cap), 64'(want));
    endtask

    initial begin
        #(5.0 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; slot_mask = '0; slot_len = 6'd32;
        fsync = 1'b0; buf_data = '0; buf_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R10 reset state
        check(cfg_rdata == 32'd0, "R10 cfg reset", 64'(cfg_rdata), 64'd0);
        check(sdo == 1'b0, "R10 sdo reset", 64'(sdo), 64'd0);
        check(underrun == 1'b0, "R10 underrun reset", 64'(underrun), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reserved bits ignore writes and read zero
        write_cfg(32'hFFFFFFFF);

        foreach (VECS[i]) begin
            write_cfg(VECS[i].cfg);
            slot_mask = VECS[i].mask;
            slot_len  = VECS[i].slot;
            run_slot(VECS[i].data, 1'b1, int'(VECS[i].eff), int'(VECS[i].dly), VECS[i].exp,
                     $sformatf("vector %0d pin trace (R2 R3 R4 R5 R6 R7 R8)", i));
        end

        // R9: empty buffer resends the last word
        write_cfg(32'h00000000);
        slot_mask = 32'hFFFFFFFF;
        slot_len  = 6'd8;
        run_slot(32'h000000C3, 1'b1, 8, 0, 32'h000000C3, "R9 fresh word");
        run_slot(32'h00000000, 1'b0, 8, 0, 32'h000000C3, "R9 resend on underrun");

        // R10: reset after activity clears the register
        write_cfg(32'h0002C000);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(cfg_rdata == 32'd0, "R10 cfg cleared", 64'(cfg_rdata), 64'd0);
        check(sdo == 1'b0, "R10 sdo cleared", 64'(sdo), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule